// File: doc/BRIEF.md
# Multi-District Program/Erase Status Register

This block keeps the outcome of automatic program and erase operations for a flash memory controller model, including multi-block operations that involve up to four districts at once. Districts are armed one by one with a setup command that carries a district index. A start command then launches the operation and the block holds the device busy for a configurable number of clock cycles. At the end of the busy period it records a pass or fail per armed district, taken from an injected-fail input. The analog program/verify loop is abstracted into that input, so a district whose loop ran out of retries is shown by presenting its fail bit at completion.

The controller reads a status byte that always shows the write-protect level and the ready/busy state. The pass/fail field depends on which status command was last issued. The single-operation view gives one aggregate result. The multi-district view adds one bit per district. Pass/fail bits are forced to pass while busy, because they are only meaningful once the device is ready again. Pulling write protect low aborts a running operation, and every district that took part is then reported as failed.

The states are IDLE (nothing armed), ARMED (one or more districts selected) and BUSY (operation running). The transitions are: IDLE to ARMED on a setup; ARMED to ARMED on a further setup; ARMED to BUSY on a start while write protect is high; ARMED to IDLE on a start while write protect is low (rejected); BUSY to IDLE when the timer expires (completed) or when write protect falls (aborted).

Top module: `nand_stat_reg`

## Requirements
- R1: After reset the block is ready (rb_n = 1), no district is armed, every district reads pass, the single-operation view is selected, and status_byte reads 8'hC0 with wp_n high.
- R2: status_byte bit 7 always equals wp_n (1 = not protected), bit 6 reads 1 when ready and 0 when busy and always equals rb_n, and bit 5 always reads 0.
- R3: A setup command (8'h80 program or 8'h60 erase) arms the district given by cmd_dist (0 to 3). Repeating it for an already armed district changes nothing. A start command (8'h10 program or 8'hD0 erase) is accepted only when at least one district is armed; otherwise it is ignored.
- R4: After an accepted start with wp_n high, rb_n is low for exactly BUSY_CYCLES clock cycles, beginning in the cycle after the start is sampled, and then returns high.
- R5: While busy, status_byte bits 4..0 all read 0 (pass), whatever the previous or pending result.
- R6: When the busy time ends, the fail flag of district i becomes inj_fail[i] if district i was armed and 0 (pass) otherwise.
- R7: Command 8'h70 selects the single view: bit 0 is the OR of all district fail flags and bits 4..1 read 0. Command 8'h71 selects the multi view: bit 0 is the same aggregate and bit 1+i is the fail flag of district i. The selection holds until the other command arrives and is accepted in any state.
- R8: An accepted start clears every fail flag, so an operation that completes with no injected fail reads pass even after a failed one.
- R9: If wp_n is low during the busy period, the block is ready in the next cycle and every armed district reads fail.
- R10: A start sampled while wp_n is low and districts are armed does not go busy. In the next cycle every armed district reads fail and all other districts read pass.
- R11: Setup and start commands sampled while busy are ignored, and command bytes outside the six listed codes are ignored in every state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command byte strobe, one cycle per command |
| cmd_byte | input | 8 | Command code |
| cmd_dist | input | 2 | District index for setup commands |
| wp_n | input | 1 | Write protect level, low = protected |
| inj_fail | input | 4 | Per-district fail flags sampled at completion |
| rb_n | output | 1 | Ready/busy, low while busy (open-drain style pull-down) |
| status_byte | output | 8 | Status byte for the selected view |

## Verification
Every result is due one clock edge after its cause. A command sampled at an edge shows its effect on rb_n and status_byte right after that edge. A completion shows up BUSY_CYCLES edges after the start edge, and a write-protect abort at the first edge that sees wp_n low. The bench drives inputs on falling edges and samples one falling edge later. It counts busy samples falling edge by falling edge, so the ready transition is checked at exactly the cycle R4 gives. The sweep covers every armed-district set against every injected-fail pattern and reads both views after each completion.

// File: rtl/nand_stat_pkg.sv
package nand_stat_pkg;

    localparam int DIST_N = 4;
    localparam int DIST_W = $clog2(DIST_N);

    localparam logic [7:0] OPC_PROG_SETUP  = 8'h80;
    localparam logic [7:0] OPC_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OPC_PROG_GO     = 8'h10;
    localparam logic [7:0] OPC_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OPC_VIEW_ONE    = 8'h70;
    localparam logic [7:0] OPC_VIEW_ALL    = 8'h71;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } st_t;

    typedef struct packed {
        logic setup;
        logic go;
        logic view_one;
        logic view_all;
    } cmd_kind_t;

endpackage

// File: rtl/nand_stat_decode.sv
module nand_stat_decode
    import nand_stat_pkg::*;
(
    input  logic       we,
    input  logic [7:0] code,
    output cmd_kind_t  kind
);
    always_comb begin
        kind = '0;
        if (we) begin
            unique case (code)
                OPC_PROG_SETUP, OPC_ERASE_SETUP: kind.setup    = 1'b1;
                OPC_PROG_GO,    OPC_ERASE_GO:    kind.go       = 1'b1;
                OPC_VIEW_ONE:                    kind.view_one = 1'b1;
                OPC_VIEW_ALL:                    kind.view_all = 1'b1;
                default:                         kind          = '0;
            endcase
        end
    end
endmodule

// File: rtl/nand_stat_timer.sv
module nand_stat_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] START = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_stat_fmt.sv
module nand_stat_fmt
    import nand_stat_pkg::*;
(
    input  logic              wp_n,
    input  logic              ready,
    input  logic              view_all,
    input  logic [DIST_N-1:0] fails,
    output logic [7:0]        byte_o
);
    logic [DIST_N-1:0] shown;
    logic              agg;

    always_comb begin
        shown  = (ready && view_all) ? fails : '0;
        agg    = ready && (|fails);
        byte_o = {wp_n, ready, 1'b0, shown, agg};
    end
endmodule

// File: rtl/nand_stat_reg.sv
module nand_stat_reg
    import nand_stat_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [7:0]  cmd_byte,
    input  logic [1:0]  cmd_dist,
    input  logic        wp_n,
    input  logic [3:0]  inj_fail,
    output logic        rb_n,
    output logic [7:0]  status_byte
);
    st_t               state_q, state_d;
    logic [DIST_N-1:0] mask_q,  mask_d;
    logic [DIST_N-1:0] fail_q,  fail_d;
    logic              view_q,  view_d;
    logic              tmr_load;
    logic              tmr_done;
    logic              ready;
    cmd_kind_t         kind;
    logic [DIST_N-1:0] dist_oh;

    nand_stat_decode u_dec (
        .we   (cmd_we),
        .code (cmd_byte),
        .kind (kind)
    );

    nand_stat_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_done)
    );

    assign dist_oh = DIST_N'(1) << cmd_dist;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            fail_q  <= '0;
            view_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            fail_q  <= fail_d;
            view_q  <= view_d;
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        mask_d   = mask_q;
        fail_d   = fail_q;
        view_d   = view_q;
        tmr_load = 1'b0;

        if (kind.view_all) begin
            view_d = 1'b1;
        end else if (kind.view_one) begin
            view_d = 1'b0;
        end

        unique case (state_q)
            ST_IDLE: begin
                if (kind.setup) begin
                    mask_d  = dist_oh;
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (kind.setup) begin
                    mask_d = mask_q | dist_oh;
                end else if (kind.go) begin
                    if (wp_n) begin
                        fail_d   = '0;
                        tmr_load = 1'b1;
                        state_d  = ST_BUSY;
                    end else begin
                        fail_d  = mask_q;
                        mask_d  = '0;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BUSY: begin
                if (!wp_n) begin
                    fail_d  = mask_q;
                    mask_d  = '0;
                    state_d = ST_IDLE;
                end else if (tmr_done) begin
                    fail_d  = mask_q & inj_fail;
                    mask_d  = '0;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                mask_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready = (state_q != ST_BUSY);
        rb_n  = ready;
    end

    nand_stat_fmt u_fmt (
        .wp_n     (wp_n),
        .ready    (ready),
        .view_all (view_q),
        .fails    (fail_q),
        .byte_o   (status_byte)
    );
endmodule

// File: rtl/nand_stat_chk.sv
module nand_stat_chk #(
    parameter int BUSY_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [7:0] cmd_byte,
    input logic       wp_n,
    input logic       rb_n,
    input logic [7:0] status_byte
);
    localparam int LW = $clog2(BUSY_CYCLES + 2) + 1;

    logic [LW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (!rb_n) begin
            busy_len <= busy_len + 1'b1;
        end else begin
            busy_len <= '0;
        end
    end

    a_r2_wp_bit: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[7] == wp_n);

    a_r2_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[6] == rb_n);

    a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[5] == 1'b0);

    a_r4_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> ($past(cmd_we) &&
                         ($past(cmd_byte) == 8'h10 || $past(cmd_byte) == 8'hD0)));

    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= LW'(BUSY_CYCLES));

    a_r5_masked_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_n |-> (status_byte[4:0] == 5'b0));

    a_r9_wp_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_n && !wp_n) |=> rb_n);
endmodule

bind nand_stat_reg nand_stat_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_byte    (cmd_byte),
    .wp_n        (wp_n),
    .rb_n        (rb_n),
    .status_byte (status_byte)
);

// File: tb/nand_stat_reg_bench.sv
`timescale 1ns/1ps
module nand_stat_reg_bench;
    localparam int NB = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [1:0] cmd_dist = 2'd0;
    logic       wp_n = 1'b1;
    logic [3:0] inj_fail = 4'h0;
    logic       rb_n;
    logic [7:0] status_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nand_stat_reg #(.BUSY_CYCLES(NB)) u_nand_stat_reg (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .cmd_dist(cmd_dist), .wp_n(wp_n), .inj_fail(inj_fail),
        .rb_n(rb_n), .status_byte(status_byte)
    );

    function automatic logic [7:0] exp_stat(input logic wp, input logic rdy,
                                            input logic all, input logic [3:0] f);
        logic [3:0] sh;
        sh = (rdy && all) ? f : 4'h0;
        return {wp, rdy, 1'b0, sh, rdy && (|f)};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // drive on a falling edge, return one falling edge later (result visible)
    task automatic issue(input logic [7:0] code, input logic [1:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_byte = code; cmd_dist = d;
        @(negedge clk);
        cmd_we = 1'b0; cmd_byte = 8'h00;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        logic [3:0] last_f;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", status_byte, 8'hC0);
        chk("R1 rb_n", {7'd0, rb_n}, 8'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", status_byte, 8'hC0);

        // R3 start with nothing armed, and R11 unknown code, are ignored
        issue(8'h11, 2'd2);
        chk("R11 unknown code", status_byte, 8'hC0);
        issue(8'h10, 2'd0);
        chk("R3 start unarmed ignored", {7'd0, rb_n}, 8'd1);
        chk("R3 start unarmed status", status_byte, 8'hC0);

        // R2 protect bit follows wp_n while idle
        @(negedge clk); wp_n = 1'b0;
        #1 chk("R2 wp low bit7", status_byte, 8'h40);
        @(negedge clk); wp_n = 1'b1;
        #1 chk("R2 wp high bit7", status_byte, 8'hC0);

        // sweep: every armed set against every injected pattern
        last_f = 4'h0;
        for (int m = 1; m < 16; m++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] mm, ff, ef;
                mm = 4'(m); ff = 4'(f);
                ef = mm & ff;
                for (int d = 0; d < 4; d++)
                    if (mm[d]) issue(d[0] ? 8'h60 : 8'h80, 2'(d));
                for (int d = 0; d < 4; d++)
                    if (mm[d]) begin issue(8'h80, 2'(d)); break; end
                // R8: previous result still visible until start
                issue(8'h71, 2'd0);
                chk("R8 old result before start", status_byte, exp_stat(1'b1, 1'b1, 1'b1, last_f));
                @(negedge clk); inj_fail = ff;
                issue((f % 2 == 0) ? 8'h10 : 8'hD0, 2'd0);
                for (int c = 0; c < NB; c++) begin
                    chk("R4 busy", {7'd0, rb_n}, 8'd0);
                    chk("R5 masked busy", status_byte, exp_stat(1'b1, 1'b0, 1'b1, 4'h0));
                    if (c == 1) begin
                        // R11 setup/start while busy ignored (edge after this negedge)
                        cmd_we = 1'b1; cmd_byte = 8'h80; cmd_dist = 2'd3;
                    end else if (c == 2) begin
                        cmd_we = 1'b1; cmd_byte = 8'hD0;
                    end else begin
                        cmd_we = 1'b0; cmd_byte = 8'h00;
                    end
                    @(negedge clk);
                end
                cmd_we = 1'b0; cmd_byte = 8'h00;
                chk("R4 ready after BUSY_CYCLES", {7'd0, rb_n}, 8'd1);
                chk("R6 R11 multi view result", status_byte, exp_stat(1'b1, 1'b1, 1'b1, ef));
                issue(8'h70, 2'd0);
                chk("R7 single view", status_byte, exp_stat(1'b1, 1'b1, 1'b0, ef));
                issue(8'h71, 2'd0);
                chk("R7 multi view", status_byte, exp_stat(1'b1, 1'b1, 1'b1, ef));
                last_f = ef;
            end
        end

        // R8 clean run after a failing run
        inj_fail = 4'hF;
        issue(8'h80, 2'd1); issue(8'h10, 2'd0);
        repeat (NB) @(negedge clk);
        chk("R8 fail run", status_byte, exp_stat(1'b1, 1'b1, 1'b1, 4'b0010));
        inj_fail = 4'h0;
        issue(8'h60, 2'd1); issue(8'hD0, 2'd0);
        repeat (NB) @(negedge clk);
        chk("R8 cleared to pass", status_byte, exp_stat(1'b1, 1'b1, 1'b1, 4'b0000));

        // R9 write protect during busy
        issue(8'h60, 2'd0); issue(8'h60, 2'd2); issue(8'hD0, 2'd0);
        @(negedge clk);
        chk("R9 busy before abort", {7'd0, rb_n}, 8'd0);
        wp_n = 1'b0;
        @(negedge clk);
        chk("R9 ready after abort", {7'd0, rb_n}, 8'd1);
        chk("R9 armed fail", status_byte, exp_stat(1'b0, 1'b1, 1'b1, 4'b0101));
        wp_n = 1'b1;

        // R10 start while protected
        @(negedge clk); wp_n = 1'b0;
        issue(8'h80, 2'd0); issue(8'h80, 2'd1); issue(8'h10, 2'd0);
        chk("R10 no busy", {7'd0, rb_n}, 8'd1);
        chk("R10 armed fail", status_byte, exp_stat(1'b0, 1'b1, 1'b1, 4'b0011));
        issue(8'h70, 2'd0);
        chk("R10 single view", status_byte, exp_stat(1'b0, 1'b1, 1'b0, 4'b0011));
        wp_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        report();
    end
endmodule